// File: doc/BRIEF.md
# Line Pixel Statistics Engine

This block watches a stream of digitised pixel words for one colour channel and produces per-line quality figures. Each line is framed by a start marker and an end marker. Only words flagged by the valid strobe inside that frame are counted, and only up to a fixed number of pixels per line. The block keeps the running sum of these pixels and the largest distance of any pixel from a reference level. From these it derives the line mean after the end marker.

The peak-deviation pass needs a mean before the line is seen. Rather than buffer a whole line, the block uses the mean of the previous completed line as its reference, so the first line after reset produces no valid deviation. Three operating modes are supported:

- In shielded mode the mean is the average dark level and the peak deviation is the dark non-uniformity.
- In illuminated mode the block also reports the peak deviation as a whole-number percentage of the reference mean.
- In noise mode the block picks one pixel position and follows it over a batch of lines. It then reports the population variance of that pixel.

All divisions share one sequential divider. While a line is collected or divided the block is busy and ignores new start markers. Results appear together with a one-cycle done pulse and hold until the next pulse.

Top module: `pxstat_line_stats`

## Requirements
- R1: A pixel is accepted only when pix_vld is high while a line is open, from the cycle after an accepted line_start up to and including the cycle carrying line_end. At most PIX pixels per line are accepted; further valid pixels and any pixel outside an open line leave every result unchanged.
- R2: On done, mean equals the floor of the sum of the accepted pixels divided by PIX.
- R3: On done, peak_dev equals the largest absolute difference between an accepted pixel and the mean reported for the previous line, and res_valid is 1. For the first line after reset, res_valid is 0 and peak_dev is 0.
- R4: In illuminated mode (mode = 2'b01), with res_valid set and a non-zero previous mean, pct equals floor(peak_dev × 100 / previous mean).
- R5: In illuminated mode with res_valid set and a previous mean of zero, err_zero is 1 and pct is 0. In every other case err_zero is 0.
- R6: In noise mode (mode = 2'b10) the accepted pixel whose 0-based index equals sel_pix (latched at line start) is collected once per line. On the done of the NLINES-th collected line, var_valid is 1 and variance equals floor((NLINES·Σs² − (Σs)²) / NLINES²). The batch then restarts empty. On all other lines var_valid and variance are 0.
- R7: A line that starts in any mode other than noise discards a partly collected noise batch, so the next noise line begins a new batch.
- R8: busy is 1 from the cycle after an accepted line_start until done. A line_start while busy is ignored, including its mode and sel_pix. done is a single-cycle pulse during which busy is 0.
- R9: mode 2'b00 (shielded) and mode 2'b11 behave identically. Outside illuminated mode pct is 0 and err_zero is 0.
- R10: After reset busy, done, res_valid, err_zero, var_valid, mean, peak_dev, pct and variance are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 00 shielded, 01 illuminated, 10 noise, 11 as shielded; latched at line start |
| sel_pix | input | IDX_W | Pixel index followed in noise mode; latched at line start |
| line_start | input | 1 | Opens a line when the block is idle |
| line_end | input | 1 | Closes the open line; the pixel in this cycle still counts |
| pix_vld | input | 1 | Pixel data word is valid |
| pix_data | input | DATA_W | Pixel value |
| busy | output | 1 | Line open or results being computed |
| done | output | 1 | One-cycle pulse: results updated |
| res_valid | output | 1 | Deviation used a previous-line mean |
| err_zero | output | 1 | Percentage not computed because the reference mean was zero |
| var_valid | output | 1 | Variance of a completed noise batch is present |
| mean | output | DATA_W | Line mean |
| peak_dev | output | DATA_W | Largest absolute deviation from the reference mean |
| pct | output | PCT_W | Peak deviation as a percentage of the reference mean |
| variance | output | 2·DATA_W | Variance of the followed pixel over the batch |

## Verification
The bench drives the first line after reset and expects a zero deviation with res_valid low; a design that used a reset-zero mean as reference would report the raw pixel peak instead. Lines carry surplus valid pixels, gaps, stray pixels before the start and after the end marker, and a second start marker mid-line. Any of these being taken would shift the mean, and a restart would also lose the sum. An all-zero line followed by an illuminated line exercises the zero-mean error. A full-scale line followed by an all-zero line must give exactly 100 percent. Noise batches are broken by a shielded line and also fed a constant pixel, so a design that kept stale sums or counted the wrong index yields a wrong or non-zero variance.

// File: rtl/pxstat_pkg.sv
package pxstat_pkg;

    typedef enum logic [1:0] {
        MODE_DARK  = 2'b00,
        MODE_LIGHT = 2'b01,
        MODE_NOISE = 2'b10,
        MODE_ALT   = 2'b11
    } pxmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LINE,
        ST_MEAN_GO,
        ST_MEAN_WAIT,
        ST_PCT_WAIT,
        ST_VAR_WAIT,
        ST_FINISH
    } pxstate_e;

    typedef struct packed {
        logic res_ok;
        logic div0;
        logic var_ok;
    } pxflags_t;

    localparam int PCT_SCALE = 100;
    localparam int PCT_BITS  = 7;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pxstat_divu.sv
module pxstat_divu #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quot
);
    localparam int CW = $clog2(NUM_W + 1);

    logic             run;
    logic [CW-1:0]    cnt;
    logic [DEN_W-1:0] rem;
    logic [DEN_W-1:0] den_q;
    logic [NUM_W-1:0] q;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    always_comb begin
        shifted = {rem, q[NUM_W-1]};
        diff    = shifted - {1'b0, den_q};
        fits    = shifted >= {1'b0, den_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run   <= 1'b0;
            cnt   <= '0;
            rem   <= '0;
            den_q <= '0;
            q     <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q     <= num;
                rem   <= '0;
                den_q <= den;
                cnt   <= CW'(NUM_W);
                run   <= 1'b1;
            end else if (run) begin
                rem <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                q   <= {q[NUM_W-2:0], fits};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q;

    // R8: the controller never restarts a division that is still running
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);

    // R8: a finished division leaves the divider idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !run);

endmodule

// File: rtl/pxstat_line_acc.sv
module pxstat_line_acc #(
    parameter int DATA_W = 12,
    parameter int PIX    = 10600,
    parameter int IDX_W  = 14,
    parameter int SUM_W  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              take,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] ref_mean,
    input  logic              ref_ok,
    input  logic [IDX_W-1:0]  sel,
    output logic [SUM_W-1:0]  sum_o,
    output logic [DATA_W-1:0] maxdev_o,
    output logic [DATA_W-1:0] sample_o
);
    localparam int CNT_W = $clog2(PIX + 1);

    logic [CNT_W-1:0]  cnt;
    logic              room;
    logic [DATA_W-1:0] absdiff;

    always_comb begin
        room    = cnt < CNT_W'(PIX);
        absdiff = (din >= ref_mean) ? (din - ref_mean) : (ref_mean - din);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt      <= '0;
            sum_o    <= '0;
            maxdev_o <= '0;
            sample_o <= '0;
        end else if (take && room) begin
            cnt   <= cnt + 1'b1;
            sum_o <= sum_o + SUM_W'(din);
            if (ref_ok && (absdiff > maxdev_o))
                maxdev_o <= absdiff;
            if (cnt == CNT_W'(sel))
                sample_o <= din;
        end
    end

    // R1: never more than PIX pixels enter a line
    a_r1_cnt_cap: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(PIX));

    // R3: the peak deviation only grows within a line
    a_r3_peak_mono: assert property (@(posedge clk) disable iff (rst)
        !clear |=> maxdev_o >= $past(maxdev_o));

endmodule

// File: rtl/pxstat_noise_acc.sv
module pxstat_noise_acc #(
    parameter int DATA_W = 12,
    parameter int NLINES = 100,
    parameter int NB     = 7,
    parameter int NSUM_W = 19,
    parameter int NSQ_W  = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              add,
    input  logic [DATA_W-1:0] sample,
    output logic [NSUM_W-1:0] nsum,
    output logic [NSQ_W-1:0]  nsq,
    output logic [NB-1:0]     ncnt
);
    logic [2*DATA_W-1:0] sq;

    always_comb sq = sample * sample;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            nsum <= '0;
            nsq  <= '0;
            ncnt <= '0;
        end else if (add) begin
            nsum <= nsum + NSUM_W'(sample);
            nsq  <= nsq + NSQ_W'(sq);
            ncnt <= ncnt + 1'b1;
        end
    end

    // R6: a batch never holds more than NLINES samples
    a_r6_batch_cap: assert property (@(posedge clk) disable iff (rst)
        ncnt <= NB'(NLINES));

endmodule

// File: rtl/pxstat_line_stats.sv
module pxstat_line_stats
    import pxstat_pkg::*;
#(
    parameter  int DATA_W = 12,
    parameter  int PIX    = 10600,
    parameter  int NLINES = 100,
    localparam int IDX_W  = (PIX > 1) ? $clog2(PIX) : 1,
    localparam int PCT_W  = DATA_W + PCT_BITS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          mode,
    input  logic [IDX_W-1:0]    sel_pix,
    input  logic                line_start,
    input  logic                line_end,
    input  logic                pix_vld,
    input  logic [DATA_W-1:0]   pix_data,
    output logic                busy,
    output logic                done,
    output logic                res_valid,
    output logic                err_zero,
    output logic                var_valid,
    output logic [DATA_W-1:0]   mean,
    output logic [DATA_W-1:0]   peak_dev,
    output logic [PCT_W-1:0]    pct,
    output logic [2*DATA_W-1:0] variance
);
    localparam int SUM_W  = DATA_W + $clog2(PIX + 1);
    localparam int NB     = $clog2(NLINES + 1);
    localparam int NSUM_W = DATA_W + NB;
    localparam int NSQ_W  = 2 * DATA_W + NB;
    localparam int VNUM_W = 2 * DATA_W + 2 * NB;
    localparam int NUM_W  = imax(imax(SUM_W, PCT_W), VNUM_W);
    localparam int DEN_W  = imax(imax($clog2(PIX + 1), DATA_W), 2 * NB);

    pxstate_e          state;
    pxmode_e           mode_q;
    logic [IDX_W-1:0]  sel_q;
    logic              have_mean;
    logic [DATA_W-1:0] prev_mean;
    logic [DATA_W-1:0] new_mean;
    logic [PCT_W-1:0]  pct_st;
    logic [2*DATA_W-1:0] var_st;
    pxflags_t          flg;

    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] maxdev;
    logic [DATA_W-1:0] sample;
    logic [NSUM_W-1:0] nsum;
    logic [NSQ_W-1:0]  nsq;
    logic [NB-1:0]     ncnt;

    logic              acc_clear, acc_take, ns_clear, ns_add;
    logic              div_start, div_done;
    logic [NUM_W-1:0]  div_num, quot;
    logic [DEN_W-1:0]  div_den;
    logic              pct_go, var_go;

    always_comb begin
        acc_clear = (state == ST_IDLE) && line_start;
        acc_take  = (state == ST_LINE) && pix_vld;
        ns_clear  = (acc_clear && (pxmode_e'(mode) != MODE_NOISE))
                 || ((state == ST_VAR_WAIT) && div_done);
        ns_add    = (state == ST_MEAN_GO) && (mode_q == MODE_NOISE);
        pct_go    = (mode_q == MODE_LIGHT) && have_mean && (prev_mean != '0);
        var_go    = (mode_q == MODE_NOISE) && (ncnt == NB'(NLINES));
        div_start = 1'b0;
        div_num   = '0;
        div_den   = '0;
        if (state == ST_MEAN_GO) begin
            div_start = 1'b1;
            div_num   = NUM_W'(sum);
            div_den   = DEN_W'(PIX);
        end else if ((state == ST_MEAN_WAIT) && div_done && pct_go) begin
            div_start = 1'b1;
            div_num   = NUM_W'(maxdev) * NUM_W'(PCT_SCALE);
            div_den   = DEN_W'(prev_mean);
        end else if ((state == ST_MEAN_WAIT) && div_done && var_go) begin
            div_start = 1'b1;
            div_num   = NUM_W'(NLINES) * NUM_W'(nsq) - NUM_W'(nsum) * NUM_W'(nsum);
            div_den   = DEN_W'(NLINES * NLINES);
        end
    end

    pxstat_line_acc #(
        .DATA_W(DATA_W), .PIX(PIX), .IDX_W(IDX_W), .SUM_W(SUM_W)
    ) u_acc (
        .clk(clk), .rst(rst), .clear(acc_clear), .take(acc_take),
        .din(pix_data), .ref_mean(prev_mean), .ref_ok(have_mean),
        .sel(sel_q), .sum_o(sum), .maxdev_o(maxdev), .sample_o(sample)
    );

    pxstat_noise_acc #(
        .DATA_W(DATA_W), .NLINES(NLINES), .NB(NB),
        .NSUM_W(NSUM_W), .NSQ_W(NSQ_W)
    ) u_noise (
        .clk(clk), .rst(rst), .clear(ns_clear), .add(ns_add),
        .sample(sample), .nsum(nsum), .nsq(nsq), .ncnt(ncnt)
    );

    pxstat_divu #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
        .clk(clk), .rst(rst), .start(div_start), .num(div_num),
        .den(div_den), .done(div_done), .quot(quot)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            mode_q    <= MODE_DARK;
            sel_q     <= '0;
            have_mean <= 1'b0;
            prev_mean <= '0;
            new_mean  <= '0;
            pct_st    <= '0;
            var_st    <= '0;
            flg       <= '0;
            done      <= 1'b0;
            res_valid <= 1'b0;
            err_zero  <= 1'b0;
            var_valid <= 1'b0;
            mean      <= '0;
            peak_dev  <= '0;
            pct       <= '0;
            variance  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (line_start) begin
                    mode_q <= pxmode_e'(mode);
                    sel_q  <= sel_pix;
                    state  <= ST_LINE;
                end
                ST_LINE: if (line_end) state <= ST_MEAN_GO;
                ST_MEAN_GO: begin
                    pct_st     <= '0;
                    var_st     <= '0;
                    flg.res_ok <= have_mean;
                    flg.div0   <= (mode_q == MODE_LIGHT) && have_mean && (prev_mean == '0);
                    flg.var_ok <= 1'b0;
                    state      <= ST_MEAN_WAIT;
                end
                ST_MEAN_WAIT: if (div_done) begin
                    new_mean <= quot[DATA_W-1:0];
                    if (pct_go)      state <= ST_PCT_WAIT;
                    else if (var_go) state <= ST_VAR_WAIT;
                    else             state <= ST_FINISH;
                end
                ST_PCT_WAIT: if (div_done) begin
                    pct_st <= quot[PCT_W-1:0];
                    state  <= ST_FINISH;
                end
                ST_VAR_WAIT: if (div_done) begin
                    var_st     <= quot[2*DATA_W-1:0];
                    flg.var_ok <= 1'b1;
                    state      <= ST_FINISH;
                end
                ST_FINISH: begin
                    done      <= 1'b1;
                    mean      <= new_mean;
                    peak_dev  <= maxdev;
                    res_valid <= flg.res_ok;
                    err_zero  <= flg.div0;
                    pct       <= pct_st;
                    variance  <= var_st;
                    var_valid <= flg.var_ok;
                    prev_mean <= new_mean;
                    have_mean <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: block is free again when results are presented
    a_r8_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R5: a zero-mean error never comes with a percentage value
    a_r5_err_no_pct: assert property (@(posedge clk) disable iff (rst)
        err_zero |-> (pct == '0));

    // R6: variance validity only appears with a result
    a_r6_var_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(var_valid) |-> done);

    // R9: no percentage or error outside illuminated mode
    a_r9_dark_no_pct: assert property (@(posedge clk) disable iff (rst)
        (done && (mode_q != MODE_LIGHT)) |-> ((pct == '0) && !err_zero));

endmodule

// File: tb/tb_pxstat_line_stats.sv
module tb_pxstat_line_stats;
    localparam int CLK_PERIOD = 10;
    localparam int DW   = 12;
    localparam int PIX  = 16;
    localparam int NL   = 4;
    localparam int IW   = 4;
    localparam int PW   = DW + 7;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      mode = '0;
    logic [IW-1:0]   sel_pix = '0;
    logic            line_start = 1'b0, line_end = 1'b0, pix_vld = 1'b0;
    logic [DW-1:0]   pix_data = '0;
    logic            busy, done, res_valid, err_zero, var_valid;
    logic [DW-1:0]   mean, peak_dev;
    logic [PW-1:0]   pct;
    logic [2*DW-1:0] variance;

    pxstat_line_stats #(.DATA_W(DW), .PIX(PIX), .NLINES(NL)) dut (
        .clk(clk), .rst(rst), .mode(mode), .sel_pix(sel_pix),
        .line_start(line_start), .line_end(line_end), .pix_vld(pix_vld),
        .pix_data(pix_data), .busy(busy), .done(done), .res_valid(res_valid),
        .err_zero(err_zero), .var_valid(var_valid), .mean(mean),
        .peak_dev(peak_dev), .pct(pct), .variance(variance)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int     n_chk = 0, n_bad = 0;
    int     vals[0:31];
    int     lcg = 12345;
    int     prev_mean = 0;
    bit     have_mean = 0;
    int     nbuf[$];
    longint cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 150000);
        n_bad++;
        $display("FAIL R8 watchdog expired: actual %0d expected 0", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd();
        lcg = lcg * 1103515245 + 12345;
        return (lcg >>> 8) & 4095;
    endfunction

    task automatic fill(input int kind);
        for (int i = 0; i < 32; i++) begin
            case (kind)
                0: vals[i] = rnd();
                1: vals[i] = 0;
                2: vals[i] = 4095;
                default: vals[i] = 200;
            endcase
        end
    endtask

    task automatic run_line(input int m, input int sel, input int gap,
                            input int extra, input bit poke, input string focus);
        int     total, s, mx, exp_mean, exp_dev, exp_pct, ad;
        bit     exp_err, exp_vv, seen;
        longint vs, vq, exp_var;
        total = PIX + extra;
        // stray pixel while idle: must be ignored (R1)
        @(negedge clk);
        pix_vld = 1'b1; pix_data = 12'hFFF;
        @(negedge clk);
        pix_vld = 1'b0;
        mode = 2'(m); sel_pix = IW'(sel); line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk("R8", busy, 1);
        for (int i = 0; i < total; i++) begin
            if (gap != 0 && (i % gap) == 1) begin
                pix_vld = 1'b0; pix_data = DW'(rnd());
                if (poke && i == 5) begin
                    line_start = 1'b1; mode = 2'(m ^ 1); sel_pix = IW'(sel + 1);
                end
                @(negedge clk);
                line_start = 1'b0;
            end
            pix_vld = 1'b1; pix_data = DW'(vals[i]);
            line_end = (i == total - 1);
            @(negedge clk);
        end
        pix_vld = 1'b0; line_end = 1'b0;
        @(negedge clk);
        pix_vld = 1'b1; pix_data = 12'hFFF;   // after the end marker (R1)
        @(negedge clk);
        pix_vld = 1'b0;
        seen = 0;
        for (int k = 0; k < 3000; k++) begin
            if (done) begin seen = 1; break; end
            @(negedge clk);
        end
        chk("R8", seen, 1);
        chk("R8", busy, 0);
        // reference model
        s = 0; mx = 0;
        for (int i = 0; i < PIX; i++) begin
            s += vals[i];
            ad = vals[i] - prev_mean;
            if (ad < 0) ad = -ad;
            if (have_mean && ad > mx) mx = ad;
        end
        exp_mean = s / PIX;
        exp_dev  = mx;
        exp_pct  = 0; exp_err = 0;
        if (m == 1 && have_mean) begin
            if (prev_mean == 0) exp_err = 1;
            else exp_pct = (mx * 100) / prev_mean;
        end
        exp_vv = 0; exp_var = 0;
        if (m != 2) nbuf.delete();
        else begin
            nbuf.push_back(vals[sel]);
            if (nbuf.size() == NL) begin
                vs = 0; vq = 0;
                foreach (nbuf[j]) begin vs += nbuf[j]; vq += longint'(nbuf[j]) * nbuf[j]; end
                exp_var = (NL * vq - vs * vs) / (NL * NL);
                exp_vv  = 1;
                nbuf.delete();
            end
        end
        chk((focus != "") ? focus : "R2", mean, exp_mean);
        chk("R3", res_valid, have_mean);
        chk("R3", peak_dev, exp_dev);
        chk("R4", pct, exp_pct);
        chk("R5", err_zero, exp_err);
        chk((focus != "") ? focus : "R6", var_valid, exp_vv);
        chk((focus != "") ? focus : "R6", variance, exp_var);
        prev_mean = exp_mean;
        have_mean = 1;
        @(negedge clk);
        chk("R8", done, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", busy, 0);
        chk("R10", done, 0);
        chk("R10", res_valid | err_zero | var_valid, 0);
        chk("R10", mean, 0);
        chk("R10", peak_dev, 0);
        chk("R10", pct, 0);
        chk("R10", variance, 0);

        fill(0); run_line(0, 0, 0, 0, 0, "R3");     // first line: no reference
        fill(0); run_line(0, 0, 3, 4, 1, "R1");     // gaps, surplus, restart poke
        fill(0); run_line(1, 0, 0, 0, 0, "R4");
        fill(1); run_line(0, 0, 2, 0, 0, "R2");     // all zero
        fill(0); run_line(1, 0, 0, 0, 0, "R5");     // zero reference
        fill(2); run_line(3, 0, 0, 0, 0, "R9");     // full scale, alt mode
        fill(1); run_line(1, 0, 0, 0, 0, "R4");     // exactly 100 percent
        for (int l = 0; l < NL; l++) begin fill(0); run_line(2, 3, 0, 0, 0, "R6"); end
        for (int l = 0; l < 2; l++) begin fill(0); run_line(2, 7, 0, 0, 0, "R7"); end
        fill(0); run_line(0, 0, 0, 0, 0, "R7");
        for (int l = 0; l < NL; l++) begin fill(0); run_line(2, 15, 4, 0, 0, "R7"); end
        for (int l = 0; l < NL; l++) begin fill(3); run_line(2, 0, 0, 0, 0, "R6"); end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule